// File: doc/BRIEF.md
# Radio Interrupt Routing and FIFO Control

This block drives the two interrupt pins of a packet-mode radio receiver/transmitter. Each pin carries one of several internal status signals. The choice depends on whether the radio is receiving or transmitting. In receive, each pin has its own 2-bit select. In transmit, a single select bit is shared by both pins. Both pins are registered, so a change of mode or select cannot produce a glitch on the pin.

The block also holds a small control register. This register does four jobs:
- It decides whether the receive FIFO starts filling by itself on a start-pattern detection or is filled under software control.
- It keeps a sticky FIFO overflow flag. Writing 1 to this flag clears it and sends a one-cycle FIFO reset pulse.
- It gates the RSSI threshold status onto the interrupt path.
- It either passes the PLL lock status to a dedicated pin or holds that pin high.

The reset input is asynchronous and active-low, and its release is synchronized inside the block.

Top module: `irq_router`

## Requirements
- R1: While reset is held, and after its release until the first stimulus, irq0, irq1, fifo_fill and fifo_reset are 0, lock_pin is 1 and cfg_rdata is 0x00.
- R2: In receive (tx_mode=0), irq0 follows the source picked by rx_sel0: 0 = packet ready with good CRC (st_pkt_rdy), 1 = byte written to FIFO (st_byte_wr), 2 = FIFO not empty (inverse of st_fifo_empty), 3 = start pattern detected or address matched (st_start_det OR st_addr_match).
- R3: In transmit (tx_mode=1), irq0 follows st_fifo_thr when tx_sel=1 and the inverse of st_fifo_empty when tx_sel=0.
- R4: In receive, irq1 follows the source picked by rx_sel1: 0 = st_crc_ok, 1 = st_fifo_full, 2 = gated RSSI status (R10), 3 = st_fifo_thr.
- R5: In transmit, irq1 follows st_fifo_full when tx_sel=0 and st_tx_done when tx_sel=1.
- R6: irq0 and irq1 are registered. A change on any input shows on a pin one clock edge later, never before that edge.
- R7: cfg_wdata/cfg_rdata bit 0 is the fill-mode bit. When bit 0 is 0, a start detection during receive sets fifo_fill to 1. fifo_fill stays 1 until transmit mode, or a write that clears the overflow, brings it back to 0. In this mode, cfg_rdata bit 1 shows fifo_fill.
- R8: When bit 0 is 1, fifo_fill equals register bit 1 (1 = fill, 0 = stop). Start detections and the mode have no effect on fifo_fill.
- R9: Register bit 2 is a sticky overflow flag, set by st_fifo_ovf. Writing 1 to bit 2 clears the flag and makes fifo_reset high for exactly one cycle. Writing 0 to bit 2 leaves the flag unchanged. If an overflow event and a clearing write arrive together, the flag stays set.
- R10: Register bit 3 is the RSSI interrupt enable. Bit 4 reads st_rssi_above AND bit 3, and this same value is the irq1 source for receive select 2.
- R11: Register bit 5 enables the lock output. When it is 0, lock_pin is 1. When it is 1, lock_pin follows st_pll_lock one cycle later.
- R12: Writes have no effect on bit 4 or on bits 7..6. Bits 7..6 always read 0. Bits 0, 1, 3 and 5 are read/write and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| rx_sel0 | input | 2 | irq0 source select in receive |
| rx_sel1 | input | 2 | irq1 source select in receive |
| tx_sel | input | 1 | Source select for both pins in transmit |
| st_pkt_rdy | input | 1 | Packet ready with good CRC |
| st_crc_ok | input | 1 | CRC check passed |
| st_byte_wr | input | 1 | Pulse when a received byte enters the FIFO |
| st_fifo_empty | input | 1 | FIFO is empty |
| st_fifo_full | input | 1 | FIFO is full |
| st_fifo_thr | input | 1 | FIFO threshold interrupt |
| st_start_det | input | 1 | Start pattern detected |
| st_addr_match | input | 1 | Node address matched |
| st_rssi_above | input | 1 | Signal strength at or above threshold |
| st_tx_done | input | 1 | All FIFO bits transmitted |
| st_fifo_ovf | input | 1 | FIFO overflow event |
| st_pll_lock | input | 1 | PLL locked |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| irq0 | output | 1 | Interrupt pin 0 |
| irq1 | output | 1 | Interrupt pin 1 |
| fifo_fill | output | 1 | Receive FIFO fill enable |
| fifo_reset | output | 1 | One-cycle FIFO reset pulse |
| lock_pin | output | 1 | PLL lock indicator pin |

## Verification
Every interrupt pin result and every lock_pin result is due one edge after the input that causes it. A register write is due in cfg_rdata, fifo_fill and fifo_reset one edge after the strobe. A routed value that depends on a freshly written enable (RSSI on irq1, the lock output) is due two edges after the write, because the enable register and the output register each add one. The gated RSSI status bit is combinational and so is due at once. The bench drives inputs on the falling edge and samples at the next falling edge, or one edge later for the two-register paths. The registered-output requirement is also probed a fraction of a cycle after the stimulus, before the rising edge, to show that the pin has not moved yet.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int CFG_W     = 8;
  localparam int RX_SEL_W  = 2;
  localparam int N_RX_SRC  = 1 << RX_SEL_W;
  localparam int N_TX_SRC  = 2;
  localparam int N_PINS    = 2;
  localparam int RST_STAGES = 2;

  // control register field positions
  localparam int B_MANUAL  = 0;
  localparam int B_FILL    = 1;
  localparam int B_OVF     = 2;
  localparam int B_RSSI_EN = 3;
  localparam int B_RSSI_ST = 4;
  localparam int B_LOCK_EN = 5;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_pin_mux.sv
module irq_pin_mux #(
  parameter int SEL_W = 2,
  parameter int N_RX  = 1 << SEL_W,
  parameter int N_TX  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_mode,
  input  logic [SEL_W-1:0] rx_sel,
  input  logic             tx_sel,
  input  logic [N_RX-1:0]  rx_src,
  input  logic [N_TX-1:0]  tx_src,
  output logic             irq
);
  logic irq_d, irq_q;

  always_comb begin
    if (tx_mode) irq_d = tx_src[tx_sel];
    else         irq_d = rx_src[rx_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_router_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             tx_mode,
  input  logic             start_det,
  input  logic             ovf_evt,
  input  logic             rssi_above,
  input  logic             pll_lock,
  output logic [CFG_W-1:0] rdata,
  output logic             fifo_fill,
  output logic             fifo_reset,
  output logic             rssi_irq,
  output logic             lock_pin
);
  logic manual_q, fill_on_q, rssi_en_q, lock_en_q;
  logic auto_fill_q, auto_fill_d;
  logic ovf_q, ovf_d;
  logic fifo_rst_q, fifo_rst_d;
  logic lock_pin_q, lock_pin_d;
  logic wr_clr;
  logic unused_hi;

  assign wr_clr    = wr_en & wdata[B_OVF];
  assign unused_hi = ^wdata[CFG_W-1:B_LOCK_EN+1] ^ wdata[B_RSSI_ST];

  // next-state logic
  always_comb begin
    auto_fill_d = auto_fill_q;
    if (tx_mode || wr_clr) auto_fill_d = 1'b0;
    else if (start_det)    auto_fill_d = 1'b1;
    ovf_d      = ovf_evt | (ovf_q & ~wr_clr);
    fifo_rst_d = wr_clr;
    lock_pin_d = lock_en_q ? pll_lock : 1'b1;
  end

  // configuration bits, written under the write-strobe enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      manual_q  <= 1'b0;
      fill_on_q <= 1'b0;
      rssi_en_q <= 1'b0;
      lock_en_q <= 1'b0;
    end else if (wr_en) begin
      manual_q  <= wdata[B_MANUAL];
      fill_on_q <= wdata[B_FILL];
      rssi_en_q <= wdata[B_RSSI_EN];
      lock_en_q <= wdata[B_LOCK_EN];
    end
  end

  // status and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_fill_q <= 1'b0;
      ovf_q       <= 1'b0;
      fifo_rst_q  <= 1'b0;
      lock_pin_q  <= 1'b1;
    end else begin
      auto_fill_q <= auto_fill_d;
      ovf_q       <= ovf_d;
      fifo_rst_q  <= fifo_rst_d;
      lock_pin_q  <= lock_pin_d;
    end
  end

  assign fifo_fill  = manual_q ? fill_on_q : auto_fill_q;
  assign fifo_reset = fifo_rst_q;
  assign rssi_irq   = rssi_en_q & rssi_above;
  assign lock_pin   = lock_pin_q;

  always_comb begin
    rdata            = '0;
    rdata[B_MANUAL]  = manual_q;
    rdata[B_FILL]    = fifo_fill;
    rdata[B_OVF]     = ovf_q;
    rdata[B_RSSI_EN] = rssi_en_q;
    rdata[B_RSSI_ST] = rssi_irq;
    rdata[B_LOCK_EN] = lock_en_q;
  end

  // R9: overflow flag holds until a write of 1 clears it
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !wr_clr |=> ovf_q);
  // R9: a clearing write produces the reset pulse
  a_r9_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[B_OVF] |=> fifo_reset);
  // R11: disabled lock output drives the pin high
  a_r11_lock_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en_q |=> lock_pin);
  // R7: transmit mode stops automatic filling
  a_r7_tx_stops_fill: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode && !manual_q && !wr_en |=> !fifo_fill);
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_mode,
  input  logic [RX_SEL_W-1:0] rx_sel0,
  input  logic [RX_SEL_W-1:0] rx_sel1,
  input  logic                tx_sel,
  input  logic                st_pkt_rdy,
  input  logic                st_crc_ok,
  input  logic                st_byte_wr,
  input  logic                st_fifo_empty,
  input  logic                st_fifo_full,
  input  logic                st_fifo_thr,
  input  logic                st_start_det,
  input  logic                st_addr_match,
  input  logic                st_rssi_above,
  input  logic                st_tx_done,
  input  logic                st_fifo_ovf,
  input  logic                st_pll_lock,
  input  logic                cfg_wr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  output logic                irq0,
  output logic                irq1,
  output logic                fifo_fill,
  output logic                fifo_reset,
  output logic                lock_pin
);
  logic srst_n;
  logic rssi_irq;
  logic [N_RX_SRC-1:0] rx_src [N_PINS];
  logic [N_TX_SRC-1:0] tx_src [N_PINS];
  logic [RX_SEL_W-1:0] rx_sel [N_PINS];
  logic [N_PINS-1:0]   irq_vec;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  // pin 0 sources, indexed by select value
  assign rx_src[0] = {st_start_det | st_addr_match, ~st_fifo_empty, st_byte_wr, st_pkt_rdy};
  assign tx_src[0] = {st_fifo_thr, ~st_fifo_empty};
  assign rx_sel[0] = rx_sel0;
  // pin 1 sources
  assign rx_src[1] = {st_fifo_thr, rssi_irq, st_fifo_full, st_crc_ok};
  assign tx_src[1] = {st_tx_done, st_fifo_full};
  assign rx_sel[1] = rx_sel1;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    irq_pin_mux #(.SEL_W(RX_SEL_W), .N_RX(N_RX_SRC), .N_TX(N_TX_SRC)) u_mux (
      .clk(clk), .rst_n(srst_n), .tx_mode(tx_mode),
      .rx_sel(rx_sel[p]), .tx_sel(tx_sel),
      .rx_src(rx_src[p]), .tx_src(tx_src[p]),
      .irq(irq_vec[p])
    );
  end

  assign irq0 = irq_vec[0];
  assign irq1 = irq_vec[1];

  irq_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(srst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
    .tx_mode(tx_mode), .start_det(st_start_det), .ovf_evt(st_fifo_ovf),
    .rssi_above(st_rssi_above), .pll_lock(st_pll_lock),
    .rdata(cfg_rdata), .fifo_fill(fifo_fill), .fifo_reset(fifo_reset),
    .rssi_irq(rssi_irq), .lock_pin(lock_pin)
  );

  // R2: receive select 2 shows FIFO not empty on irq0
  a_r2_rx_not_empty: assert property (@(posedge clk) disable iff (!srst_n)
    !tx_mode && rx_sel0 == 2'd2 && !st_fifo_empty |=> irq0);
  // R3: transmit select 1 shows FIFO threshold on irq0
  a_r3_tx_thr: assert property (@(posedge clk) disable iff (!srst_n)
    tx_mode && tx_sel && st_fifo_thr |=> irq0);
  // R5: transmit select 1 shows transmit done on irq1
  a_r5_tx_done: assert property (@(posedge clk) disable iff (!srst_n)
    tx_mode && tx_sel && st_tx_done |=> irq1);
  // R4: receive select 1 shows FIFO full on irq1
  a_r4_rx_full: assert property (@(posedge clk) disable iff (!srst_n)
    !tx_mode && rx_sel1 == 2'd1 && !st_fifo_full |=> !irq1);
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_mode, tx_sel;
  logic [1:0] rx_sel0, rx_sel1;
  logic st_pkt_rdy, st_crc_ok, st_byte_wr, st_fifo_empty, st_fifo_full, st_fifo_thr;
  logic st_start_det, st_addr_match, st_rssi_above, st_tx_done, st_fifo_ovf, st_pll_lock;
  logic       cfg_wr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic irq0, irq1, fifo_fill, fifo_reset, lock_pin;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .rx_sel0(rx_sel0), .rx_sel1(rx_sel1),
    .tx_sel(tx_sel), .st_pkt_rdy(st_pkt_rdy), .st_crc_ok(st_crc_ok), .st_byte_wr(st_byte_wr),
    .st_fifo_empty(st_fifo_empty), .st_fifo_full(st_fifo_full), .st_fifo_thr(st_fifo_thr),
    .st_start_det(st_start_det), .st_addr_match(st_addr_match), .st_rssi_above(st_rssi_above),
    .st_tx_done(st_tx_done), .st_fifo_ovf(st_fifo_ovf), .st_pll_lock(st_pll_lock),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq0(irq0), .irq1(irq1),
    .fifo_fill(fifo_fill), .fifo_reset(fifo_reset), .lock_pin(lock_pin)
  );

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    st_pkt_rdy = 0; st_crc_ok = 0; st_byte_wr = 0; st_fifo_empty = 1;
    st_fifo_full = 0; st_fifo_thr = 0; st_start_det = 0; st_addr_match = 0;
    st_rssi_above = 0; st_tx_done = 0; st_fifo_ovf = 0;
  endtask

  task automatic wr(logic [7:0] v);
    cfg_wr = 1; cfg_wdata = v;
    step();
    cfg_wr = 0; cfg_wdata = 8'h00;
  endtask

  task automatic t_reset();
    rst_n = 0; tx_mode = 0; tx_sel = 0; rx_sel0 = 0; rx_sel1 = 0;
    cfg_wr = 0; cfg_wdata = 0; st_pll_lock = 0;
    idle();
    step(); step();
    chk("R1 irq0 in reset", 8'(irq0), 8'h0);
    chk("R1 irq1 in reset", 8'(irq1), 8'h0);
    chk("R1 lock_pin in reset", 8'(lock_pin), 8'h1);
    chk("R1 rdata in reset", cfg_rdata, 8'h00);
    rst_n = 1;
    step(); step(); step();
    chk("R1 fifo_fill after reset", 8'(fifo_fill), 8'h0);
    chk("R1 fifo_reset after reset", 8'(fifo_reset), 8'h0);
    chk("R1 lock_pin after reset", 8'(lock_pin), 8'h1);
    chk("R1 rdata after reset", cfg_rdata, 8'h00);
  endtask

  task automatic t_irq0_rx();
    tx_mode = 0; idle(); rx_sel0 = 0; step();
    chk("R2 sel0 idle", 8'(irq0), 8'h0);
    st_byte_wr = 1; step();
    chk("R2 sel0 ignores byte_wr", 8'(irq0), 8'h0);
    st_pkt_rdy = 1; step();
    chk("R2 sel0 pkt_rdy", 8'(irq0), 8'h1);
    idle(); rx_sel0 = 1; step();
    chk("R2 sel1 idle", 8'(irq0), 8'h0);
    st_byte_wr = 1; step();
    chk("R2 sel1 byte_wr", 8'(irq0), 8'h1);
    idle(); rx_sel0 = 2; step();
    chk("R2 sel2 empty", 8'(irq0), 8'h0);
    st_fifo_empty = 0; step();
    chk("R2 sel2 not empty", 8'(irq0), 8'h1);
    idle(); rx_sel0 = 3; step();
    chk("R2 sel3 idle", 8'(irq0), 8'h0);
    st_addr_match = 1; step();
    chk("R2 sel3 addr match", 8'(irq0), 8'h1);
    st_addr_match = 0; st_start_det = 1; step();
    chk("R2 sel3 start det", 8'(irq0), 8'h1);
    idle();
  endtask

  task automatic t_irq0_tx();
    tx_mode = 1; tx_sel = 1; idle(); step();
    chk("R3 sel1 idle", 8'(irq0), 8'h0);
    st_fifo_empty = 0; step();
    chk("R3 sel1 ignores not-empty", 8'(irq0), 8'h0);
    st_fifo_thr = 1; step();
    chk("R3 sel1 threshold", 8'(irq0), 8'h1);
    tx_sel = 0; idle(); step();
    chk("R3 sel0 empty", 8'(irq0), 8'h0);
    st_fifo_thr = 1; step();
    chk("R3 sel0 ignores threshold", 8'(irq0), 8'h0);
    st_fifo_empty = 0; step();
    chk("R3 sel0 not empty", 8'(irq0), 8'h1);
    idle();
  endtask

  task automatic t_irq1_rx();
    tx_mode = 0; idle(); rx_sel1 = 0; step();
    chk("R4 sel0 idle", 8'(irq1), 8'h0);
    st_crc_ok = 1; step();
    chk("R4 sel0 crc ok", 8'(irq1), 8'h1);
    idle(); rx_sel1 = 1; st_crc_ok = 1; step();
    chk("R4 sel1 ignores crc", 8'(irq1), 8'h0);
    st_fifo_full = 1; step();
    chk("R4 sel1 full", 8'(irq1), 8'h1);
    idle(); rx_sel1 = 3; step();
    chk("R4 sel3 idle", 8'(irq1), 8'h0);
    st_fifo_thr = 1; step();
    chk("R4 sel3 threshold", 8'(irq1), 8'h1);
    idle();
  endtask

  task automatic t_irq1_tx();
    tx_mode = 1; tx_sel = 0; idle(); st_tx_done = 1; step();
    chk("R5 sel0 ignores tx_done", 8'(irq1), 8'h0);
    st_fifo_full = 1; step();
    chk("R5 sel0 full", 8'(irq1), 8'h1);
    tx_sel = 1; idle(); st_fifo_full = 1; step();
    chk("R5 sel1 ignores full", 8'(irq1), 8'h0);
    st_tx_done = 1; step();
    chk("R5 sel1 tx done", 8'(irq1), 8'h1);
    idle();
  endtask

  task automatic t_registered();
    tx_mode = 0; rx_sel0 = 1; idle(); step();
    st_byte_wr = 1; #1;
    chk("R6 no change before edge", 8'(irq0), 8'h0);
    step();
    chk("R6 change after edge", 8'(irq0), 8'h1);
    st_byte_wr = 0; #1;
    chk("R6 holds before edge", 8'(irq0), 8'h1);
    step();
    chk("R6 falls after edge", 8'(irq0), 8'h0);
  endtask

  task automatic t_auto_fill();
    idle(); wr(8'h00);
    tx_mode = 1; step(); tx_mode = 0; step();
    chk("R7 auto idle", 8'(fifo_fill), 8'h0);
    st_start_det = 1; step(); st_start_det = 0;
    chk("R7 auto start", 8'(fifo_fill), 8'h1);
    chk("R7 readback bit1", 8'(cfg_rdata[1]), 8'h1);
    step();
    chk("R7 auto holds", 8'(fifo_fill), 8'h1);
    tx_mode = 1; step();
    chk("R7 tx stops fill", 8'(fifo_fill), 8'h0);
    tx_mode = 0;
  endtask

  task automatic t_manual_fill();
    idle(); tx_mode = 0; wr(8'h01);
    chk("R8 manual off", 8'(fifo_fill), 8'h0);
    st_start_det = 1; step(); st_start_det = 0;
    chk("R8 start ignored", 8'(fifo_fill), 8'h0);
    wr(8'h03);
    chk("R8 manual on", 8'(fifo_fill), 8'h1);
    tx_mode = 1; step();
    chk("R8 mode ignored", 8'(fifo_fill), 8'h1);
    wr(8'h01);
    chk("R8 manual stop", 8'(fifo_fill), 8'h0);
    tx_mode = 0; wr(8'h00);
  endtask

  task automatic t_overflow();
    idle(); wr(8'h00);
    st_fifo_ovf = 1; step(); st_fifo_ovf = 0;
    chk("R9 flag set", 8'(cfg_rdata[2]), 8'h1);
    step();
    chk("R9 flag sticky", 8'(cfg_rdata[2]), 8'h1);
    wr(8'h00);
    chk("R9 write 0 keeps flag", 8'(cfg_rdata[2]), 8'h1);
    chk("R9 write 0 no pulse", 8'(fifo_reset), 8'h0);
    wr(8'h04);
    chk("R9 write 1 clears", 8'(cfg_rdata[2]), 8'h0);
    chk("R9 reset pulse", 8'(fifo_reset), 8'h1);
    step();
    chk("R9 pulse one cycle", 8'(fifo_reset), 8'h0);
    st_fifo_ovf = 1; cfg_wr = 1; cfg_wdata = 8'h04; step();
    st_fifo_ovf = 0; cfg_wr = 0; cfg_wdata = 8'h00;
    chk("R9 set wins", 8'(cfg_rdata[2]), 8'h1);
    chk("R9 pulse with set", 8'(fifo_reset), 8'h1);
    wr(8'h04);
  endtask

  task automatic t_rssi();
    idle(); wr(8'h00);
    tx_mode = 0; rx_sel1 = 2; st_rssi_above = 1; step();
    chk("R10 gated off status", 8'(cfg_rdata[4]), 8'h0);
    step();
    chk("R10 gated off irq1", 8'(irq1), 8'h0);
    wr(8'h08);
    chk("R10 enabled status", 8'(cfg_rdata[4]), 8'h1);
    step();
    chk("R10 enabled irq1", 8'(irq1), 8'h1);
    st_rssi_above = 0; step();
    chk("R10 below status", 8'(cfg_rdata[4]), 8'h0);
    chk("R10 below irq1", 8'(irq1), 8'h0);
    wr(8'h00);
  endtask

  task automatic t_lock();
    idle(); st_pll_lock = 0; wr(8'h00); step();
    chk("R11 disabled unlocked", 8'(lock_pin), 8'h1);
    st_pll_lock = 1; step();
    chk("R11 disabled locked", 8'(lock_pin), 8'h1);
    st_pll_lock = 0; wr(8'h20); step();
    chk("R11 enabled unlocked", 8'(lock_pin), 8'h0);
    st_pll_lock = 1; step();
    chk("R11 enabled locked", 8'(lock_pin), 8'h1);
    st_pll_lock = 0; step();
    chk("R11 follows loss", 8'(lock_pin), 8'h0);
    wr(8'h00); step();
    chk("R11 disabled again", 8'(lock_pin), 8'h1);
  endtask

  task automatic t_readonly();
    idle(); tx_mode = 0; wr(8'hFF);
    chk("R12 write all ones", cfg_rdata, 8'h2B);
    wr(8'h00); st_rssi_above = 1;
    wr(8'hF7);
    chk("R12 status bit ignores write", cfg_rdata, 8'h23);
    idle(); wr(8'h00);
    chk("R12 cleared", cfg_rdata, 8'h00);
  endtask

  initial begin
    t_reset();
    t_irq0_rx();
    t_irq0_tx();
    t_irq1_rx();
    t_irq1_tx();
    t_registered();
    t_auto_fill();
    t_manual_fill();
    t_overflow();
    t_rssi();
    t_lock();
    t_readonly();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule